// File: doc/BRIEF.md
# Tagged Command Stream Packet Decoder

This block sits between a command-fetch DMA engine and a register bank. It takes a stream of 32-bit words on a valid/ready input. Some of those words are packet headers and the rest are data words. The block turns them into register writes, each one a byte address plus a 32-bit data value, presented on a valid/ready write port. A header word picks how the data words that follow it are steered:

- **Hold run:** every data word goes to one register.
- **Incrementing run:** the register moves up by one tag after each data word.
- **Indexed sparse write:** a 16-bit mask picks which registers of a 16-register group receive the data words.

A single tag/data pair is a hold run of length one.

The data path has no storage. While a data word is expected, the input word goes straight to the write port. The input is stalled exactly when the write port is stalled. Header words are consumed in one cycle each and produce no write.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A register tag is 13 bits, taken from header bits 12:0. Each write address is the tag shifted left by 3 (`wr_addr_o = {tag, 3'b000}`). Header bit 13 is ignored.
- R2: A header with mode field (bits 15:14) equal to 0 and count field (bits 26:16) equal to 0 is a plain pair. The next word is written to the tagged register, and the word after it is a header.
- R3: A mode-0 header with count field N makes the next N+1 data words all write the same address. Header bits 31:27 are ignored.
- R4: A mode-1 header with count field N makes the next N+1 data words write consecutive tags, starting at the header tag. The address rises by 8 per word and the tag wraps modulo 2^13.
- R5: A mode-2 header carries a mask in bits 31:16 and a group base equal to the header tag with its low 4 bits cleared. One data word is taken per set mask bit, lowest bit first, and set bit i writes tag base+i.
- R6: A mode-2 header with an all-zero mask takes no data words. The next word is parsed as a header.
- R7: A mode-3 header sets `err_o`, which stays high until reset. The header is otherwise handled as a plain pair (one data word to its tag).
- R8: A count field of 2047 gives a run of 2048 data words.
- R9: While a header is expected, `in_ready_o` is 1 and `wr_valid_o` is 0. While data is expected, `wr_valid_o` follows `in_valid_i`, `in_ready_o` follows `wr_ready_i`, and `wr_data_o` is the input word. No word is dropped or repeated.
- R10: While `rst_n` is low at a clock edge, the decoder returns to expecting a header and clears `err_o`, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_word_i | input | 32 | Input command-stream word |
| in_ready_o | output | 1 | Decoder accepts the input word |
| wr_valid_o | output | 1 | Register write valid |
| wr_addr_o | output | 16 | Register byte address |
| wr_data_o | output | 32 | Register write data |
| wr_ready_i | input | 1 | Register bank accepts the write |
| err_o | output | 1 | Sticky flag: reserved header mode seen |

## Verification
The bench builds the decoder with its default parameters: 16-bit addresses (13-bit tags), an 11-bit count field and a 16-bit mask. These settings make the longest run of 2048 words and the tag wrap at the top of the address space reachable within a short run. Valid and ready are toggled in patterns that do not line up with each other, so stalls land on header words, on the first and last word of runs, and inside indexed groups. The test ends with a reset applied in the middle of a run.

// File: rtl/cmdp_pkg.sv
// cmdp_pkg: shared field positions and header mode encoding for the
// command stream decoder. Assumes 32-bit stream words.
package cmdp_pkg;
    localparam int MODE_LSB  = 14;   // mode field occupies bits 15:14
    localparam int FIELD_LSB = 16;   // count or mask field starts here

    typedef enum logic [1:0] {
        PK_HOLD  = 2'd0,
        PK_INCR  = 2'd1,
        PK_INDEX = 2'd2,
        PK_RSVD  = 2'd3
    } pkt_mode_e;

    typedef enum logic [1:0] {
        S_HDR = 2'd0,   // waiting for a header word
        S_RUN = 2'd1,   // hold or increment run in progress
        S_IDX = 2'd2    // indexed group in progress
    } dec_state_e;
endpackage

// File: rtl/cmdp_hdr_decode.sv
// cmdp_hdr_decode: pure combinational split of a header word into its
// fields. Assumes TAG_W <= 14 and FIELD_LSB + max(CNT_W, MASK_W) <= WORD_W.
module cmdp_hdr_decode
    import cmdp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TAG_W  = 13,
    parameter int CNT_W  = 11,
    parameter int MASK_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output pkt_mode_e         mode_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [TAG_W-1:0]  base_o,
    output logic [CNT_W-1:0]  cnt_m1_o,
    output logic [MASK_W-1:0] mask_o
);
    localparam int GRP_LSB = $clog2(MASK_W);

    // Field extraction; group base has the in-group index bits cleared.
    always_comb begin
        mode_o   = pkt_mode_e'(word_i[MODE_LSB +: 2]);
        tag_o    = word_i[TAG_W-1:0];
        base_o   = {word_i[TAG_W-1:GRP_LSB], {GRP_LSB{1'b0}}};
        cnt_m1_o = word_i[FIELD_LSB +: CNT_W];
        mask_o   = word_i[FIELD_LSB +: MASK_W];
    end
endmodule

// File: rtl/cmdp_mask_scan.sv
// cmdp_mask_scan: finds the lowest set bit of a mask, returns its index
// and the mask with that bit removed. Assumes the caller only uses idx_o
// when the mask is non-zero.
module cmdp_mask_scan #(
    parameter int MASK_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [MASK_W-1:0] mask_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [MASK_W-1:0] rest_o,
    output logic              rest_any_o
);
    logic [MASK_W-1:0] lowest;
    logic [IDX_W-1:0]  bit_idx [MASK_W];

    // Isolate the lowest set bit with two's complement.
    always_comb lowest = mask_i & (~mask_i + MASK_W'(1));

    // One index term per mask position; zero unless that bit is lowest.
    for (genvar g = 0; g < MASK_W; g++) begin : g_term
        assign bit_idx[g] = lowest[g] ? IDX_W'(g) : '0;
    end

    // OR-combine the one-hot index terms and strip the consumed bit.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < MASK_W; i++) idx_o = idx_o | bit_idx[i];
        rest_o     = mask_i & ~lowest;
        rest_any_o = |rest_o;
    end
endmodule

// File: rtl/cmd_stream_decoder.sv
// cmd_stream_decoder: turns a tagged command word stream into register
// writes. Data words pass straight through to the write port (no storage),
// so the input stalls exactly when the write port stalls. Headers take one
// cycle each. Assumes a 32-bit stream and MASK_W a power of two.
module cmd_stream_decoder
    import cmdp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 11,
    parameter int MASK_W = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [WORD_W-1:0] in_word_i,
    output logic              in_ready_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    input  logic              wr_ready_i,
    output logic              err_o
);
    localparam int TAG_W = ADDR_W - 3;
    localparam int IDX_W = $clog2(MASK_W);

    dec_state_e        state_q;
    logic [TAG_W-1:0]  tag_q;
    logic [TAG_W-1:0]  base_q;
    logic [CNT_W-1:0]  rem_q;
    logic              incr_q;
    logic [MASK_W-1:0] mask_q;
    logic              err_q;

    pkt_mode_e         h_mode;
    logic [TAG_W-1:0]  h_tag;
    logic [TAG_W-1:0]  h_base;
    logic [CNT_W-1:0]  h_cnt;
    logic [MASK_W-1:0] h_mask;

    logic [IDX_W-1:0]  sc_idx;
    logic [MASK_W-1:0] sc_rest;
    logic              sc_rest_any;

    logic              hdr_fire;
    logic              data_fire;
    logic [TAG_W-1:0]  cur_tag;

    cmdp_hdr_decode #(
        .WORD_W (WORD_W),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W),
        .MASK_W (MASK_W)
    ) hdr_i (
        .word_i   (in_word_i),
        .mode_o   (h_mode),
        .tag_o    (h_tag),
        .base_o   (h_base),
        .cnt_m1_o (h_cnt),
        .mask_o   (h_mask)
    );

    cmdp_mask_scan #(
        .MASK_W (MASK_W),
        .IDX_W  (IDX_W)
    ) scan_i (
        .mask_i     (mask_q),
        .idx_o      (sc_idx),
        .rest_o     (sc_rest),
        .rest_any_o (sc_rest_any)
    );

    // Port handshake and the tag of the data word now on the input.
    always_comb begin
        hdr_fire   = (state_q == S_HDR) && in_valid_i;
        data_fire  = (state_q != S_HDR) && in_valid_i && wr_ready_i;
        cur_tag    = (state_q == S_IDX) ? (base_q + TAG_W'(sc_idx)) : tag_q;
        in_ready_o = (state_q == S_HDR) || wr_ready_i;
        wr_valid_o = (state_q != S_HDR) && in_valid_i;
        wr_addr_o  = {cur_tag, 3'b000};
        wr_data_o  = in_word_i;
        err_o      = err_q;
    end

    // Packet sequencing: load on header, advance on each accepted data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_HDR;
            tag_q   <= '0;
            base_q  <= '0;
            rem_q   <= '0;
            incr_q  <= 1'b0;
            mask_q  <= '0;
            err_q   <= 1'b0;
        end else if (hdr_fire) begin
            tag_q <= h_tag;
            case (h_mode)
                PK_HOLD: begin
                    rem_q   <= h_cnt;
                    incr_q  <= 1'b0;
                    state_q <= S_RUN;
                end
                PK_INCR: begin
                    rem_q   <= h_cnt;
                    incr_q  <= 1'b1;
                    state_q <= S_RUN;
                end
                PK_INDEX: begin
                    base_q  <= h_base;
                    mask_q  <= h_mask;
                    state_q <= (|h_mask) ? S_IDX : S_HDR;
                end
                default: begin
                    err_q   <= 1'b1;
                    rem_q   <= '0;
                    incr_q  <= 1'b0;
                    state_q <= S_RUN;
                end
            endcase
        end else if (data_fire) begin
            if (state_q == S_RUN) begin
                if (rem_q == '0) begin
                    state_q <= S_HDR;
                end else begin
                    rem_q <= rem_q - CNT_W'(1);
                    if (incr_q) tag_q <= tag_q + TAG_W'(1);
                end
            end else begin
                mask_q <= sc_rest;
                if (!sc_rest_any) state_q <= S_HDR;
            end
        end
    end

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !incr_q && data_fire && rem_q != '0) |=> $stable(wr_addr_o)); // R3
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && incr_q && data_fire && rem_q != '0) |=> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(8))); // R4
    AST_IDX_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDX && data_fire) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1)); // R5
    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDX && data_fire && sc_rest_any) |=> (wr_addr_o > $past(wr_addr_o))); // R5
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_fire && h_mode == PK_INDEX && h_mask == '0) |=> (state_q == S_HDR)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |-> !in_ready_o); // R9
endmodule

// File: tb/cmd_stream_decoder_tb_top.sv
// Bench: behavioural reference model built from queues of expected words.
module cmd_stream_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] in_word_i = '0;
    logic        in_ready_o;
    logic        wr_valid_o;
    logic [15:0] wr_addr_o;
    logic [31:0] wr_data_o;
    logic        wr_ready_i = 1'b0;
    logic        err_o;

    always #2.5 clk = ~clk;   // 200 MHz

    cmd_stream_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid_i),
        .in_word_i  (in_word_i),
        .in_ready_o (in_ready_o),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_ready_i (wr_ready_i),
        .err_o      (err_o)
    );

    // kind: 0 header, 1 data, 2 reserved-mode header
    logic [31:0] word_q[$];
    int          kind_q[$];
    logic [15:0] addr_q[$];
    string       req_q[$];
    int          vectors = 0;
    int          misses = 0;
    int          cyc = 0;
    logic [31:0] dseq = 32'hD000_0000;
    bit          exp_err = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic add_hdr(input logic [31:0] w, input int k, input string r);
        word_q.push_back(w); kind_q.push_back(k); addr_q.push_back('0); req_q.push_back(r);
    endtask

    task automatic add_dat(input logic [12:0] tag, input string r);
        word_q.push_back(dseq); kind_q.push_back(1); addr_q.push_back({tag, 3'b000}); req_q.push_back(r);
        dseq = dseq + 32'h0000_0101;
    endtask

    // Run packet: mode 0 hold or mode 1 increment, count words, junk in spare bits.
    task automatic pk_run(input bit inc, input logic [12:0] tag, input int count,
                          input logic [4:0] junk, input string r);
        logic [12:0] t = tag;
        add_hdr({junk, 11'(count - 1), 1'b0, inc, junk[0], tag}, 0, r);
        for (int i = 0; i < count; i++) begin
            add_dat(t, r);
            if (inc) t = t + 13'd1;
        end
    endtask

    task automatic pk_idx(input logic [12:0] tag, input logic [15:0] mask, input string r);
        logic [12:0] base = {tag[12:4], 4'h0};
        add_hdr({mask, 2'b10, 1'b0, tag}, 0, r);
        for (int i = 0; i < 16; i++) if (mask[i]) add_dat(base + 13'(i), r);
    endtask

    // Drive the stream until drained; compare ports against the model every cycle.
    task automatic run_stream();
        bit fired = 1'b0;
        int guard = 0;
        while (word_q.size() != 0 || fired) begin
            @(negedge clk);
            cyc++;
            guard++;
            if (fired) begin
                if (kind_q[0] == 2) exp_err = 1'b1;
                void'(word_q.pop_front()); void'(kind_q.pop_front());
                void'(addr_q.pop_front()); void'(req_q.pop_front());
            end
            wr_ready_i = (cyc % 5) != 3;
            in_valid_i = (word_q.size() != 0) && ((cyc % 7) != 2);
            in_word_i  = (word_q.size() != 0) ? word_q[0] : 32'h0;
            #1;
            check(err_o == exp_err, "R7", "err_o", 32'(err_o), 32'(exp_err));
            if (word_q.size() == 0) begin
                check(!wr_valid_o, "R9", "idle wr_valid", 32'(wr_valid_o), 0);
            end else if (kind_q[0] != 1) begin
                check(!wr_valid_o && in_ready_o, req_q[0], "header handshake",
                      {wr_valid_o, in_ready_o}, 32'b01);
            end else begin
                check(wr_valid_o == in_valid_i && in_ready_o == wr_ready_i, "R9",
                      "data handshake", {wr_valid_o, in_ready_o}, {in_valid_i, wr_ready_i});
                if (wr_valid_o) begin
                    check(wr_addr_o == addr_q[0], req_q[0], "wr_addr", 32'(wr_addr_o), 32'(addr_q[0]));
                    check(wr_data_o == word_q[0], req_q[0], "wr_data", wr_data_o, word_q[0]);
                end
            end
            fired = in_valid_i && in_ready_o;
            if (guard > 50000) begin
                check(1'b0, "watchdog", "stream hung", 32'(word_q.size()), 0);
                word_q.delete(); kind_q.delete(); addr_q.delete(); req_q.delete();
                fired = 1'b0;
            end
        end
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(err_o == 1'b0 && !wr_valid_o && in_ready_o, "R10", "reset state",
              {err_o, wr_valid_o, in_ready_o}, 32'b001);
        @(negedge clk);
        rst_n = 1'b1;

        pk_run(1'b0, 13'h0123, 1, 5'h00, "R2");      // plain pair
        pk_run(1'b0, 13'h0040, 3, 5'h00, "R3");      // hold run
        pk_run(1'b0, 13'h0041, 4, 5'h1F, "R1");      // hold, spare bits and bit 13 set
        pk_run(1'b1, 13'h1FFE, 5, 5'h00, "R4");      // increment with wrap
        pk_idx(13'h0257, 16'h8421, "R5");            // sparse group
        pk_idx(13'h0300, 16'hFFFF, "R5");            // full group
        pk_idx(13'h0444, 16'h0000, "R6");            // empty mask
        pk_run(1'b0, 13'h0555, 1, 5'h00, "R6");      // must parse as header
        run_stream();

        add_hdr({16'h0000, 2'b11, 1'b0, 13'h0066}, 2, "R7");  // reserved mode
        add_dat(13'h0066, "R7");
        pk_run(1'b1, 13'h0000, 2048, 5'h00, "R8");   // longest run
        pk_idx(13'h0010, 16'h0001, "R5");
        run_stream();

        add_hdr({5'h0, 11'd3, 2'b00, 1'b0, 13'h0077}, 0, "R10");  // cut short by reset
        add_dat(13'h0077, "R10");
        run_stream();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        exp_err = 1'b0;
        check(err_o == 1'b0 && !wr_valid_o && in_ready_o, "R10", "mid-packet reset",
              {err_o, wr_valid_o, in_ready_o}, 32'b001);
        rst_n = 1'b1;
        pk_run(1'b0, 13'h0099, 1, 5'h00, "R10");     // header expected after reset
        run_stream();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule